// File: doc/BRIEF.md
# HDLC Frame Receiver with FCS Check

This block sits behind a serial line that delivers one bit per clock. It watches the line at all times for the opening and closing flag pattern 01111110. A zero that the sender inserted after five consecutive ones is removed. The remaining bits are gathered into octets, least significant bit first. Address, control and information octets come out on a byte-wide port, one cycle at a time, with a valid strobe and a start-of-frame marker.

The last two octets before a closing flag are the frame check sequence. A small holding pipeline keeps the two newest octets back, so that the check sequence is never shown as payload. A CRC-16 runs over every octet of the frame, check sequence included. When the closing flag arrives, a one-cycle end-of-frame pulse reports two things: whether the register landed on the expected residue, and whether the frame was malformed. A run of seven or more ones aborts the frame. The receiver then waits for a new flag.

Top module: `hdlc_rx`

## Requirements
- R1: After reset, and after an abort, the receiver hunts: bits before the next flag produce no output byte and no end-of-frame pulse.
- R2: A flag followed directly by another flag (idle fill), or a closing flag with no complete octet since the last flag, produces no byte and no end-of-frame pulse.
- R3: A 0 bit received after exactly five consecutive 1 bits is discarded, so payload holding long runs of ones comes out unchanged.
- R4: The first bit received of an octet becomes bit 0 of `byte_data`.
- R5: The two most recent octets before a closing flag never appear on `byte_data`; a frame of N octets between flags yields N-2 output bytes, in the order they were received.
- R6: `byte_sof` is high together with `byte_valid` on the first output byte of a frame, and low on every other byte.
- R7: At the closing flag of a frame holding at least one octet, `frame_end` pulses for one cycle. `crc_ok` is 1 if a CRC run over all octets, check sequence included, leaves the residue 0xF0B8. The CRC is reflected, with polynomial 0x8408 and initial value 0xFFFF, and is fed LSB first. The transmitter sends the check sequence as the ones' complement of its CRC, low octet first.
- R8: `crc_ok` is 0 at the end of a frame whose check sequence does not match its contents.
- R9: `frame_err` is 1 at the end of a frame with fewer than 4 octets, or whose destuffed bit count between flags is not a multiple of 8; otherwise it is 0.
- R10: Seven consecutive 1 bits inside a frame give a one-cycle `frame_abort` pulse and no `frame_end` for that frame.
- R11: During and right after reset, `byte_valid`, `byte_sof`, `frame_end`, `frame_abort`, `crc_ok` and `frame_err` are 0.
- R12: `crc_ok` and `frame_err` keep their values until the next `frame_end` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial line bit |
| byte_data | output | 8 | Received payload octet |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_sof | output | 1 | First payload octet of a frame |
| frame_end | output | 1 | One-cycle pulse at a closing flag |
| crc_ok | output | 1 | Check-sequence result of the last frame |
| frame_err | output | 1 | Length or alignment error of the last frame |
| frame_abort | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The bench builds the block with its default parameters: a CRC-16 with residue 0xF0B8, a minimum of four octets and a hold depth of two. This puts the shortest legal frame within a few dozen bit times, and one- and zero-payload frames expose the length error. Payload octets of 0xFF and 0x7E force stuffing inside data and next to the check sequence. Directed sequences cover an abort in mid-frame, extra bits that break octet alignment, and data sent while the receiver is hunting.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam int OCTET_W        = 8;
  localparam int CRC_W          = 16;
  localparam int STUFF_RUN      = 5;
  localparam int FLAG_RUN       = 6;
  // Flag bits that enter the data path before the flag is recognised:
  // its leading zero and five ones.
  localparam int FLAG_DATA_BITS = 6;

  function automatic logic [CRC_W-1:0] crc_octet(
    input logic [CRC_W-1:0]   crc_in,
    input logic [OCTET_W-1:0] octet,
    input logic [CRC_W-1:0]   poly
  );
    logic [CRC_W-1:0] r;
    r = crc_in;
    for (int i = 0; i < OCTET_W; i++) begin
      if (r[0] ^ octet[i]) r = (r >> 1) ^ poly;
      else                 r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  output logic dv,
  output logic dbit,
  output logic flag,
  output logic abort
);
  import hdlc_rx_pkg::*;

  logic [2:0] ones_q, ones_d;
  logic       dv_d, fl_d, ab_d;

  always_comb begin
    ones_d = '0;
    dv_d   = 1'b0;
    fl_d   = 1'b0;
    ab_d   = 1'b0;
    if (rx_bit) begin
      ones_d = (ones_q == 3'd7) ? 3'd7 : ones_q + 3'd1;
      dv_d   = (ones_q < 3'(STUFF_RUN));
      ab_d   = (ones_q == 3'(FLAG_RUN));
    end else begin
      dv_d   = (ones_q < 3'(STUFF_RUN));
      fl_d   = (ones_q == 3'(FLAG_RUN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones_q <= '0;
      dv     <= 1'b0;
      dbit   <= 1'b0;
      flag   <= 1'b0;
      abort  <= 1'b0;
    end else begin
      ones_q <= ones_d;
      dv     <= dv_d;
      dbit   <= rx_bit;
      flag   <= fl_d;
      abort  <= ab_d;
    end
  end
endmodule

// File: rtl/hdlc_rx_deser.sv
module hdlc_rx_deser #(
  parameter int OCTET_BITS = 8,
  localparam int PH_W = $clog2(OCTET_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  dv,
  input  logic                  dbit,
  output logic [OCTET_BITS-1:0] octet,
  output logic                  stb,
  output logic [PH_W-1:0]       phase
);
  logic [OCTET_BITS-1:0] sh_q;
  logic [OCTET_BITS-1:0] sh_next;

  assign sh_next = {dbit, sh_q[OCTET_BITS-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      phase <= '0;
      octet <= '0;
      stb   <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (clr) begin
        phase <= '0;
      end else if (dv) begin
        sh_q <= sh_next;
        if (phase == PH_W'(OCTET_BITS - 1)) begin
          phase <= '0;
          octet <= sh_next;
          stb   <= 1'b1;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  octet,
  output logic [15:0] crc
);
  import hdlc_rx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc <= INIT;
    else if (init) crc <= INIT;
    else if (en)   crc <= crc_octet(crc, octet, POLY);
  end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx #(
  parameter logic [15:0] CRC_POLY    = 16'h8408,
  parameter logic [15:0] CRC_INIT    = 16'hFFFF,
  parameter logic [15:0] CRC_RESIDUE = 16'hF0B8,
  parameter int          MIN_OCTETS  = 4,
  parameter int          HOLD_OCTETS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_bit,
  output logic [7:0] byte_data,
  output logic       byte_valid,
  output logic       byte_sof,
  output logic       frame_end,
  output logic       crc_ok,
  output logic       frame_err,
  output logic       frame_abort
);
  import hdlc_rx_pkg::*;

  localparam int CNT_MAX = (MIN_OCTETS > HOLD_OCTETS) ? MIN_OCTETS : HOLD_OCTETS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PH_W    = $clog2(OCTET_W);

  logic               line_dv, line_bit, line_flag, line_abort;
  logic [OCTET_W-1:0] deser_octet;
  logic               deser_stb;
  logic [PH_W-1:0]    deser_phase;
  logic [CRC_W-1:0]   crc_val;

  logic               in_frame;
  logic [CNT_W-1:0]   nocts;
  logic [OCTET_W-1:0] hold_q [HOLD_OCTETS];

  logic accept, closing, aligned, too_short, release_octet;

  assign accept        = deser_stb & in_frame;
  assign closing       = line_flag & in_frame & (nocts != '0);
  assign aligned       = (deser_phase == PH_W'(FLAG_DATA_BITS % OCTET_W));
  assign too_short     = (nocts < CNT_W'(MIN_OCTETS));
  assign release_octet = accept & (nocts >= CNT_W'(HOLD_OCTETS));

  hdlc_rx_line line_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_bit(rx_bit),
    .dv    (line_dv),
    .dbit  (line_bit),
    .flag  (line_flag),
    .abort (line_abort)
  );

  hdlc_rx_deser #(.OCTET_BITS(OCTET_W)) deser_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (line_flag | line_abort),
    .dv   (line_dv),
    .dbit (line_bit),
    .octet(deser_octet),
    .stb  (deser_stb),
    .phase(deser_phase)
  );

  hdlc_rx_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .init (line_flag | line_abort),
    .en   (accept),
    .octet(deser_octet),
    .crc  (crc_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame    <= 1'b0;
      nocts       <= '0;
      byte_data   <= '0;
      byte_valid  <= 1'b0;
      byte_sof    <= 1'b0;
      frame_end   <= 1'b0;
      frame_abort <= 1'b0;
      crc_ok      <= 1'b0;
      frame_err   <= 1'b0;
      for (int i = 0; i < HOLD_OCTETS; i++) hold_q[i] <= '0;
    end else begin
      byte_valid  <= release_octet;
      byte_sof    <= release_octet & (nocts == CNT_W'(HOLD_OCTETS));
      frame_end   <= closing;
      frame_abort <= line_abort & in_frame;
      if (release_octet) byte_data <= hold_q[HOLD_OCTETS-1];
      if (closing) begin
        crc_ok    <= (crc_val == CRC_RESIDUE);
        frame_err <= too_short | ~aligned;
      end
      if (line_flag) begin
        in_frame <= 1'b1;
        nocts    <= '0;
      end else if (line_abort) begin
        in_frame <= 1'b0;
      end else if (accept) begin
        if (nocts != CNT_W'(CNT_MAX)) nocts <= nocts + CNT_W'(1);
        hold_q[0] <= deser_octet;
        for (int i = 1; i < HOLD_OCTETS; i++) hold_q[i] <= hold_q[i-1];
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_valid,
  input logic byte_sof,
  input logic frame_end,
  input logic frame_abort,
  input logic crc_ok,
  input logic frame_err,
  input logic line_abort,
  input logic in_frame
);
  p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_frame |=> !byte_valid);

  p_sof_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sof |-> byte_valid);

  p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);

  p_abort_no_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> !frame_end);

  p_abort_hunt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_abort |=> !in_frame);

  p_status_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |-> ($stable(crc_ok) && $stable(frame_err)));
endmodule

bind hdlc_rx hdlc_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .byte_sof   (byte_sof),
  .frame_end  (frame_end),
  .frame_abort(frame_abort),
  .crc_ok     (crc_ok),
  .frame_err  (frame_err),
  .line_abort (line_abort),
  .in_frame   (in_frame)
);

// File: tb/hdlc_rx_tb_top.sv
module hdlc_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic [7:0] byte_data;
  logic       byte_valid, byte_sof, frame_end, crc_ok, frame_err, frame_abort;

  always #5 clk = ~clk;

  hdlc_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit),
    .byte_data(byte_data), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .frame_end(frame_end), .crc_ok(crc_ok), .frame_err(frame_err),
    .frame_abort(frame_abort)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor state
  logic [7:0] got [64];
  int ng = 0, sof_cnt = 0, sof_idx = -1, fe_cnt = 0, ab_cnt = 0;
  logic last_ok = 0, last_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        if (ng < 64) got[ng] = byte_data;
        if (byte_sof) begin sof_cnt++; if (sof_idx < 0) sof_idx = ng; end
        ng++;
      end
      if (frame_end) begin fe_cnt++; last_ok = crc_ok; last_err = frame_err; end
      if (frame_abort) ab_cnt++;
    end
  end

  task automatic clear_mon();
    ng = 0; sof_cnt = 0; sof_idx = -1; fe_cnt = 0; ab_cnt = 0;
  endtask

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int ones_run = 0;

  task automatic tx_raw(input bit b);
    rx_bit = b;
    @(posedge clk); #1;
  endtask

  task automatic tx_flag();
    tx_raw(0);
    for (int i = 0; i < 6; i++) tx_raw(1);
    tx_raw(0);
    ones_run = 0;
  endtask

  task automatic tx_data(input bit b);
    tx_raw(b);
    ones_run = b ? ones_run + 1 : 0;
    if (ones_run == 5) begin tx_raw(0); ones_run = 0; end
  endtask

  task automatic tx_octet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) tx_data(v[i]);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(37 * i);
  endfunction

  // {count[23:16], seed[15:8], corrupt[2], exp_ok[1], exp_err[0]}
  localparam logic [23:0] VEC [6] = '{
    {8'd2, 8'h03, 8'h02},   // shortest legal frame
    {8'd5, 8'hFF, 8'h02},   // long ones runs: stuffing
    {8'd8, 8'h5A, 8'h04},   // corrupted FCS
    {8'd1, 8'h11, 8'h03},   // 3 octets: short
    {8'd3, 8'h7E, 8'h02},   // payload holding the flag pattern
    {8'd0, 8'h00, 8'h03}    // FCS only: short
  };

  task automatic send_frame(input int n, input logic [7:0] seed, input bit corrupt);
    logic [15:0] c;
    logic [15:0] fcs;
    logic [7:0]  v;
    c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      v = pat(seed, k);
      for (int j = 0; j < 8; j++) begin
        if (c[0] != v[j]) c = {1'b0, c[15:1]} ^ 16'h8408;
        else              c = {1'b0, c[15:1]};
      end
    end
    fcs = ~c;
    if (corrupt) fcs[3] = ~fcs[3];
    tx_flag();
    for (int k = 0; k < n; k++) tx_octet(pat(seed, k));
    tx_octet(fcs[7:0]);
    tx_octet(fcs[15:8]);
    tx_flag();
    tx_flag();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    chk(!byte_valid && !byte_sof && !frame_end && !frame_abort, "R11 strobes in reset",
        int'({byte_valid, byte_sof, frame_end, frame_abort}), 0);
    chk(!crc_ok && !frame_err, "R11 status in reset", int'({crc_ok, frame_err}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!crc_ok && !frame_err && !byte_valid, "R11 after reset", int'({crc_ok, frame_err, byte_valid}), 0);

    // R1 hunting: octets before any flag are ignored
    clear_mon();
    for (int k = 0; k < 6; k++) tx_octet(8'hA5 ^ 8'(k));
    repeat (4) tx_raw(0);
    chk(ng == 0, "R1 no bytes while hunting", ng, 0);
    chk(fe_cnt == 0, "R1 no frame_end while hunting", fe_cnt, 0);

    // R2 idle fill
    clear_mon();
    repeat (6) tx_flag();
    chk(ng == 0, "R2 idle flags give no bytes", ng, 0);
    chk(fe_cnt == 0, "R2 idle flags give no frame_end", fe_cnt, 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9
    foreach (VEC[e]) begin
      int n; logic [7:0] seed; bit cor, eok, eerr;
      n = int'(VEC[e][23:16]); seed = VEC[e][15:8];
      cor = VEC[e][2]; eok = VEC[e][1]; eerr = VEC[e][0];
      clear_mon();
      send_frame(n, seed, cor);
      chk(fe_cnt == 1, $sformatf("R7 frame_end count vec%0d", e), fe_cnt, 1);
      chk(ng == n, $sformatf("R5 byte count vec%0d", e), ng, n);
      for (int k = 0; k < n && k < ng; k++)
        chk(got[k] == pat(seed, k), $sformatf("R3/R4 data vec%0d byte%0d", e, k),
            int'(got[k]), int'(pat(seed, k)));
      chk(sof_cnt == ((n > 0) ? 1 : 0) && (n == 0 || sof_idx == 0),
          $sformatf("R6 sof vec%0d", e), sof_cnt, (n > 0) ? 1 : 0);
      chk(last_ok == eok, $sformatf("R7/R8 crc_ok vec%0d", e), int'(last_ok), int'(eok));
      chk(last_err == eerr, $sformatf("R9 frame_err vec%0d", e), int'(last_err), int'(eerr));
    end

    // R10 abort in mid-frame, then hunting
    clear_mon();
    tx_flag();
    for (int k = 0; k < 4; k++) tx_octet(8'h30 + 8'(k));
    repeat (7) tx_raw(1);
    repeat (3) tx_raw(1);
    chk(ab_cnt == 1, "R10 abort pulse", ab_cnt, 1);
    chk(fe_cnt == 0, "R10 no frame_end on abort", fe_cnt, 0);
    chk(ng == 2, "R10 bytes released before abort", ng, 2);
    ones_run = 0;
    tx_raw(0);
    for (int k = 0; k < 5; k++) tx_octet(8'h42 + 8'(k));
    chk(ng == 2, "R1 no bytes after abort without flag", ng, 2);
    chk(fe_cnt == 0, "R1 no frame_end after abort without flag", fe_cnt, 0);
    clear_mon();
    send_frame(3, 8'h21, 1'b0);
    chk(fe_cnt == 1 && last_ok && !last_err, "R10 recovery frame good",
        int'({last_ok, last_err}), 2);

    // R9 misaligned frame: 4 octets plus 3 bits
    clear_mon();
    tx_flag();
    for (int k = 0; k < 4; k++) tx_octet(8'h10 + 8'(k));
    tx_data(0); tx_data(1); tx_data(0);
    tx_flag();
    tx_flag();
    chk(fe_cnt == 1, "R9 misaligned frame_end", fe_cnt, 1);
    chk(last_err == 1'b1, "R9 misaligned frame_err", int'(last_err), 1);

    // R12 status held across idle
    begin
      logic hold_ok, hold_err;
      hold_ok = crc_ok; hold_err = frame_err;
      repeat (5) tx_flag();
      chk(crc_ok == hold_ok && frame_err == hold_err, "R12 status held",
          int'({crc_ok, frame_err}), int'({hold_ok, hold_err}));
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule